// File: doc/BRIEF.md
# Variable-Page Translation Buffer

This block is a small, fully associative cache of address translations. Each slot holds a virtual base, a physical base, a page-size code (4 KB, 2 MB or 4 MB), three permission bits, an uncacheable bit and a global flag. A lookup is answered in the same cycle: the block reports a hit, the physical address and the attributes of the matching slot. Slots match by address range, so pages of different sizes live side by side in the same array.

A lookup that misses raises a one-cycle miss pulse in the next cycle, carrying the address, so that an external table walker can start. The walker later writes the result through the fill port. Slots are replaced in least-recently-used order, tracked with one small age counter per slot. Two flush commands exist: one empties the whole array, and one removes only the slots not marked global. When translation is switched off, addresses pass through unchanged.

Top module: `vpage_tlb`

## Requirements
- R1: A slot matches an address when the slot is valid, its virtual base is less than or equal to the address, and the address is below the base plus the slot's page size. Size codes are 0 = 4 KB, 1 = 2 MB, 2 = 4 MB, and code 3 is treated as 4 KB.
- R2: On a hit, `lk_paddr` is the slot's physical base ORed with the address bits below the page size. `lk_perm` and `lk_uncache` return the stored attributes, with `lk_perm` bit 2 = writable, bit 1 = user and bit 0 = no-execute.
- R3: A fill aligns both the virtual and the physical address down to the page size before storing them. It uses the lowest-numbered free slot if one exists, and otherwise the least recently used slot. The filled slot becomes the most recently used.
- R4: A hitting lookup with `lk_touch` high makes the hit slot the most recently used. With `lk_touch` low, the recency order is left unchanged.
- R5: `flush_all` invalidates every slot. `flush_local` invalidates only the slots whose global flag is clear, and the surviving slots keep their relative recency order.
- R6: With `xlat_en` low, a valid lookup reports a hit with `lk_paddr` equal to `lk_vaddr`, `lk_perm` = 3'b110 and `lk_uncache` = 0, and it never raises a miss.
- R7: A valid lookup with `xlat_en` high and no matching slot drives `lk_hit` low in the same cycle. In the next cycle, `miss_valid` is high for exactly one cycle and `miss_vaddr` holds the address. With `lk_valid` low there is neither a hit nor a miss.
- R8: If several slots match, the lowest-numbered slot supplies the result.
- R9: When commands arrive in the same cycle, the priority is `flush_all`, then `flush_local`, then fill, then touch. A command that loses has no effect at all.
- R10: After reset every slot is invalid and `miss_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_en | input | 1 | Translation enable; low selects pass-through |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | ADDR_W | Lookup virtual address |
| lk_touch | input | 1 | Refresh the recency of the hit slot |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_paddr | output | ADDR_W | Translated address |
| lk_perm | output | 3 | Permissions of the hit slot {writable, user, no-execute} |
| lk_uncache | output | 1 | Uncacheable attribute of the hit slot |
| miss_valid | output | 1 | One-cycle miss pulse, one cycle after the lookup |
| miss_vaddr | output | ADDR_W | Address that missed |
| fill_valid | input | 1 | Write a new translation |
| fill_vaddr | input | ADDR_W | Fill virtual address (aligned inside the block) |
| fill_paddr | input | ADDR_W | Fill physical address (aligned inside the block) |
| fill_size | input | 2 | Page-size code |
| fill_perm | input | 3 | Permissions {writable, user, no-execute} |
| fill_uncache | input | 1 | Uncacheable attribute |
| fill_global | input | 1 | Global flag; such slots survive `flush_local` |
| flush_all | input | 1 | Invalidate every slot |
| flush_local | input | 1 | Invalidate the non-global slots |

## Verification
The assertions assume that reset lasts at least one clock edge and that the inputs are stable around the rising edge. The fill assertion also assumes that the filled slot is not evicted in the cycle before it is looked up, which can only happen through a flush in that same cycle. The bench drives inputs one time unit after each rising edge and samples the combinational lookup outputs mid-cycle. It issues one command per cycle, except in the priority cases of R9, and it sweeps addresses across both edges of every page size, so every lookup lies clearly inside or clearly outside a resident page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_2M  = 2'd1,
        PG_4M  = 2'd2,
        PG_RSV = 2'd3
    } pg_size_e;

    typedef struct packed {
        logic wr;
        logic usr;
        logic nx;
    } perm_t;

    typedef enum logic [2:0] {
        AOP_NONE,
        AOP_TOUCH,
        AOP_FILL,
        AOP_COMPACT,
        AOP_CLEAR
    } age_op_e;

    // Number of offset bits for a page-size code; the reserved code maps to 4 KB.
    function automatic int unsigned off_bits(logic [1:0] code);
        case (pg_size_e'(code))
            PG_2M:   return 21;
            PG_4M:   return 22;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/tlb_range_match.sv
module tlb_range_match
    import tlb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              vld_i,
    input  logic [ADDR_W-1:0] vbase_i,
    input  logic [1:0]        size_i,
    input  logic [ADDR_W-1:0] va_i,
    output logic              hit_o,
    output logic [ADDR_W-1:0] offmask_o
);
    // The base is stored aligned, so the range test base <= va < base + size
    // reduces to comparing the bits above the page offset.
    always_comb begin
        offmask_o = (ADDR_W'(1) << off_bits(size_i)) - ADDR_W'(1);
        hit_o     = vld_i && ((va_i & ~offmask_o) == vbase_i);
    end
endmodule

// File: rtl/tlb_recency.sv
module tlb_recency
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int AGE_W   = 2,
    parameter int IDX_W   = 2
) (
    input  age_op_e                       op_i,
    input  logic [IDX_W-1:0]              idx_i,
    input  logic [ENTRIES-1:0]            vld_i,
    input  logic [ENTRIES-1:0]            keep_i,
    input  logic [ENTRIES-1:0][AGE_W-1:0] age_i,
    output logic [ENTRIES-1:0][AGE_W-1:0] age_o
);
    // Age 0 is most recent; valid slots always hold distinct ages 0..V-1.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            logic [AGE_W-1:0] rank;
            rank     = '0;
            age_o[i] = age_i[i];
            case (op_i)
                AOP_CLEAR: age_o[i] = '0;
                AOP_COMPACT: begin
                    for (int j = 0; j < ENTRIES; j++) begin
                        if (keep_i[j] && (j != i) && (age_i[j] < age_i[i]))
                            rank = rank + AGE_W'(1);
                    end
                    age_o[i] = keep_i[i] ? rank : '0;
                end
                AOP_FILL: begin
                    if (i == int'(idx_i))
                        age_o[i] = '0;
                    else if (vld_i[i])
                        age_o[i] = age_i[i] + AGE_W'(1);
                end
                AOP_TOUCH: begin
                    if (i == int'(idx_i))
                        age_o[i] = '0;
                    else if (vld_i[i] && (age_i[i] < age_i[idx_i]))
                        age_o[i] = age_i[i] + AGE_W'(1);
                end
                default: age_o[i] = age_i[i];
            endcase
        end
    end
endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
    import tlb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlat_en,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_vaddr,
    input  logic              lk_touch,
    output logic              lk_hit,
    output logic [ADDR_W-1:0] lk_paddr,
    output logic [2:0]        lk_perm,
    output logic              lk_uncache,
    output logic              miss_valid,
    output logic [ADDR_W-1:0] miss_vaddr,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_vaddr,
    input  logic [ADDR_W-1:0] fill_paddr,
    input  logic [1:0]        fill_size,
    input  logic [2:0]        fill_perm,
    input  logic              fill_uncache,
    input  logic              fill_global,
    input  logic              flush_all,
    input  logic              flush_local
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int AGE_W = IDX_W;
    localparam logic [AGE_W-1:0] AGE_OLDEST = AGE_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0]             glb;
        logic [ENTRIES-1:0]             unc;
        logic [ENTRIES-1:0][ADDR_W-1:0] vbase;
        logic [ENTRIES-1:0][ADDR_W-1:0] pbase;
        logic [ENTRIES-1:0][1:0]        size;
        perm_t [ENTRIES-1:0]            perm;
        logic [ENTRIES-1:0][AGE_W-1:0]  age;
        logic                           miss_v;
        logic [ADDR_W-1:0]              miss_va;
    } state_t;

    state_t s_q, s_d;

    logic [ENTRIES-1:0]             hit_vec;
    logic [ENTRIES-1:0][ADDR_W-1:0] mask_arr;
    logic                           any_hit;
    logic [IDX_W-1:0]               hit_idx;
    logic [IDX_W-1:0]               vict_idx;
    logic [ADDR_W-1:0]              fill_mask;
    age_op_e                        op_d;
    logic [IDX_W-1:0]               op_idx_d;
    logic [ENTRIES-1:0][AGE_W-1:0]  age_nx;

    // One range comparator per slot.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        tlb_range_match #(.ADDR_W(ADDR_W)) u_match (
            .vld_i    (s_q.vld[g]),
            .vbase_i  (s_q.vbase[g]),
            .size_i   (s_q.size[g]),
            .va_i     (lk_vaddr),
            .hit_o    (hit_vec[g]),
            .offmask_o(mask_arr[g])
        );
    end

    // Lowest index wins among matches; victim is lowest free slot, else oldest.
    always_comb begin
        any_hit  = |hit_vec;
        hit_idx  = '0;
        vict_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
        if (&s_q.vld) begin
            for (int i = ENTRIES - 1; i >= 0; i--) begin
                if (s_q.age[i] == AGE_OLDEST) vict_idx = IDX_W'(i);
            end
        end else begin
            for (int i = ENTRIES - 1; i >= 0; i--) begin
                if (!s_q.vld[i]) vict_idx = IDX_W'(i);
            end
        end
        fill_mask = (ADDR_W'(1) << off_bits(fill_size)) - ADDR_W'(1);
    end

    // Command arbitration: flush_all > flush_local > fill > touch.
    always_comb begin
        op_d     = AOP_NONE;
        op_idx_d = hit_idx;
        if (flush_all)
            op_d = AOP_CLEAR;
        else if (flush_local)
            op_d = AOP_COMPACT;
        else if (fill_valid) begin
            op_d     = AOP_FILL;
            op_idx_d = vict_idx;
        end else if (lk_valid && xlat_en && any_hit && lk_touch)
            op_d = AOP_TOUCH;
    end

    tlb_recency #(.ENTRIES(ENTRIES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_recency (
        .op_i  (op_d),
        .idx_i (op_idx_d),
        .vld_i (s_q.vld),
        .keep_i(s_q.vld & s_q.glb),
        .age_i (s_q.age),
        .age_o (age_nx)
    );

    // Next state.
    always_comb begin
        s_d        = s_q;
        s_d.miss_v = 1'b0;
        if (lk_valid && xlat_en && !any_hit) begin
            s_d.miss_v  = 1'b1;
            s_d.miss_va = lk_vaddr;
        end
        case (op_d)
            AOP_CLEAR:   s_d.vld = '0;
            AOP_COMPACT: s_d.vld = s_q.vld & s_q.glb;
            AOP_FILL: begin
                s_d.vld[vict_idx]   = 1'b1;
                s_d.glb[vict_idx]   = fill_global;
                s_d.unc[vict_idx]   = fill_uncache;
                s_d.vbase[vict_idx] = fill_vaddr & ~fill_mask;
                s_d.pbase[vict_idx] = fill_paddr & ~fill_mask;
                s_d.size[vict_idx]  = fill_size;
                s_d.perm[vict_idx]  = perm_t'(fill_perm);
            end
            default: ;
        endcase
        s_d.age = age_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Lookup result, same cycle.
    always_comb begin
        lk_hit     = 1'b0;
        lk_paddr   = '0;
        lk_perm    = '0;
        lk_uncache = 1'b0;
        if (lk_valid) begin
            if (!xlat_en) begin
                lk_hit   = 1'b1;
                lk_paddr = lk_vaddr;
                lk_perm  = 3'b110;
            end else if (any_hit) begin
                lk_hit     = 1'b1;
                lk_paddr   = s_q.pbase[hit_idx] | (lk_vaddr & mask_arr[hit_idx]);
                lk_perm    = s_q.perm[hit_idx];
                lk_uncache = s_q.unc[hit_idx];
            end
        end
    end

    assign miss_valid = s_q.miss_v;
    assign miss_vaddr = s_q.miss_va;

endmodule

// File: rtl/vpage_tlb_chk.sv
module vpage_tlb_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xlat_en,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_vaddr,
    input logic              lk_hit,
    input logic [ADDR_W-1:0] lk_paddr,
    input logic              miss_valid,
    input logic [ADDR_W-1:0] miss_vaddr,
    input logic              fill_valid,
    input logic [ADDR_W-1:0] fill_vaddr,
    input logic              flush_all,
    input logic              flush_local
);
    // R10
    a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !miss_valid);

    // R7
    a_r7_miss_raised: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && xlat_en && !lk_hit |=> miss_valid);

    // R7
    a_r7_miss_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> $past(lk_valid && xlat_en && !lk_hit));

    // R7
    a_r7_miss_address: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> miss_vaddr == $past(lk_vaddr));

    // R6
    a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !xlat_en |-> lk_hit && (lk_paddr == lk_vaddr));

    // R5
    a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !(lk_valid && xlat_en && lk_hit));

    // R3
    a_r3_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(fill_valid && !flush_all && !flush_local) &&
        !flush_all && lk_valid && xlat_en && (lk_vaddr == $past(fill_vaddr))
        |-> lk_hit);

    // R2
    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[11:0] == lk_vaddr[11:0]);
endmodule

bind vpage_tlb vpage_tlb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xlat_en    (xlat_en),
    .lk_valid   (lk_valid),
    .lk_vaddr   (lk_vaddr),
    .lk_hit     (lk_hit),
    .lk_paddr   (lk_paddr),
    .miss_valid (miss_valid),
    .miss_vaddr (miss_vaddr),
    .fill_valid (fill_valid),
    .fill_vaddr (fill_vaddr),
    .flush_all  (flush_all),
    .flush_local(flush_local)
);

// File: tb/tb_vpage_tlb.sv
module tb_vpage_tlb;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xlat_en = 1'b1;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_vaddr = '0;
    logic          lk_touch = 1'b0;
    logic          lk_hit;
    logic [AW-1:0] lk_paddr;
    logic [2:0]    lk_perm;
    logic          lk_uncache;
    logic          miss_valid;
    logic [AW-1:0] miss_vaddr;
    logic          fill_valid = 1'b0;
    logic [AW-1:0] fill_vaddr = '0;
    logic [AW-1:0] fill_paddr = '0;
    logic [1:0]    fill_size = '0;
    logic [2:0]    fill_perm = '0;
    logic          fill_uncache = 1'b0;
    logic          fill_global = 1'b0;
    logic          flush_all = 1'b0;
    logic          flush_local = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vpage_tlb #(.ADDR_W(AW), .ENTRIES(4)) dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic fill(input logic [AW-1:0] va, input logic [AW-1:0] pa,
                        input logic [1:0] sz, input logic [2:0] pm,
                        input logic unc, input logic glb);
        fill_valid = 1'b1; fill_vaddr = va; fill_paddr = pa; fill_size = sz;
        fill_perm = pm; fill_uncache = unc; fill_global = glb;
        step();
        fill_valid = 1'b0;
    endtask

    // Lookup: check the same-cycle result, then the miss pulse one cycle later.
    task automatic probe(input logic [AW-1:0] va, input logic touch, input logic exp_hit,
                         input logic [AW-1:0] exp_pa, input string tag);
        lk_valid = 1'b1; lk_vaddr = va; lk_touch = touch;
        #1;
        chk(lk_hit == exp_hit, {tag, " hit"}, AW'(lk_hit), AW'(exp_hit));
        if (exp_hit) chk(lk_paddr == exp_pa, {tag, " paddr"}, lk_paddr, exp_pa);
        step();
        lk_valid = 1'b0; lk_touch = 1'b0;
        chk(miss_valid == (xlat_en && !exp_hit), {tag, " miss pulse"},
            AW'(miss_valid), AW'(xlat_en && !exp_hit));
        if (miss_valid) chk(miss_vaddr == va, {tag, " miss addr"}, miss_vaddr, va);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R10: empty after reset, miss low
        chk(miss_valid == 1'b0, "R10 miss low", AW'(miss_valid), '0);
        probe(32'h0040_3000, 1'b0, 1'b0, '0, "R10 empty");

        // R6: pass-through sweep
        xlat_en = 1'b0;
        for (int k = 0; k < 16; k++) begin
            logic [AW-1:0] a;
            a = 32'h1357_0000 * k + 32'h0000_0FFF * k;
            lk_valid = 1'b1; lk_vaddr = a;
            #1;
            chk(lk_hit && lk_paddr == a, "R6 bypass addr", lk_paddr, a);
            chk(lk_perm == 3'b110 && !lk_uncache, "R6 bypass attr", AW'({lk_uncache, lk_perm}), 32'h6);
            step();
            lk_valid = 1'b0;
            chk(!miss_valid, "R6 no miss", AW'(miss_valid), '0);
        end
        xlat_en = 1'b1;

        // R7: idle lookup port gives neither hit nor miss
        lk_vaddr = 32'h0040_3000;
        #1;
        chk(!lk_hit, "R7 idle no hit", AW'(lk_hit), '0);
        step();
        chk(!miss_valid, "R7 idle no miss", AW'(miss_valid), '0);

        // R1 R2 R3: 4 KB slot A (slot 0)
        fill(32'h0040_3123, 32'h1234_5678, 2'd0, 3'b101, 1'b1, 1'b0);
        for (int k = 0; k < 16; k++) begin
            logic [AW-1:0] off;
            off = AW'(k * 32'h101);
            probe(32'h0040_3000 | off, 1'b0, 1'b1, 32'h1234_5000 | off, "R1 R2 4K sweep");
        end
        lk_valid = 1'b1; lk_vaddr = 32'h0040_3FFF;
        #1;
        chk(lk_perm == 3'b101 && lk_uncache, "R2 attributes", AW'({lk_uncache, lk_perm}), 32'hD);
        step();
        lk_valid = 1'b0;
        probe(32'h0040_2FFF, 1'b0, 1'b0, '0, "R1 4K below");
        probe(32'h0040_4000, 1'b0, 1'b0, '0, "R1 4K above");

        // 2 MB slot B (slot 1)
        fill(32'h0065_4321, 32'h8031_2345, 2'd1, 3'b100, 1'b0, 1'b0);
        probe(32'h0060_0000, 1'b0, 1'b1, 32'h8020_0000, "R1 R3 2M low");
        probe(32'h007F_FFFF, 1'b0, 1'b1, 32'h803F_FFFF, "R1 R2 2M top");
        probe(32'h005F_FFFF, 1'b0, 1'b0, '0, "R1 2M below");
        probe(32'h0080_0000, 1'b0, 1'b0, '0, "R1 2M above");

        // 4 MB slot C, global (slot 2)
        fill(32'h0C12_3456, 32'h4000_0000, 2'd2, 3'b010, 1'b0, 1'b1);
        probe(32'h0C3F_FFFF, 1'b0, 1'b1, 32'h403F_FFFF, "R1 R2 4M top");
        probe(32'h0C40_0000, 1'b0, 1'b0, '0, "R1 4M above");
        probe(32'h0BFF_FFFF, 1'b0, 1'b0, '0, "R1 4M below");

        // R3 R4: recency. D fills slot 3; order D,C,B,A
        fill(32'h0100_0000, 32'h0D00_0000, 2'd0, 3'b100, 1'b0, 1'b0);
        probe(32'h0040_3010, 1'b1, 1'b1, 32'h1234_5010, "R4 touch A");
        probe(32'h0060_0010, 1'b0, 1'b1, 32'h8020_0010, "R4 untouched B");
        // order A,D,C,B: E replaces B
        fill(32'h0200_0000, 32'h0E00_0000, 2'd0, 3'b100, 1'b0, 1'b1);
        probe(32'h0060_0010, 1'b0, 1'b0, '0, "R3 R4 B evicted");
        probe(32'h0040_3010, 1'b0, 1'b1, 32'h1234_5010, "R4 A kept");
        probe(32'h0C00_0010, 1'b0, 1'b1, 32'h4000_0010, "R3 C kept");
        // order E,A,D,C: F replaces C
        fill(32'h0300_0000, 32'h0F00_0000, 2'd0, 3'b100, 1'b0, 1'b0);
        probe(32'h0C00_0010, 1'b0, 1'b0, '0, "R3 C evicted");
        probe(32'h0100_0010, 1'b0, 1'b1, 32'h0D00_0010, "R3 D kept");

        // R5: flush_local keeps only global E
        flush_local = 1'b1; step(); flush_local = 1'b0;
        probe(32'h0040_3010, 1'b0, 1'b0, '0, "R5 local A gone");
        probe(32'h0100_0010, 1'b0, 1'b0, '0, "R5 local D gone");
        probe(32'h0300_0010, 1'b0, 1'b0, '0, "R5 local F gone");
        probe(32'h0200_0010, 1'b0, 1'b1, 32'h0E00_0010, "R5 local E kept");
        // E is oldest after three fills; the fourth replaces it
        fill(32'h0400_0000, 32'h1400_0000, 2'd0, 3'b100, 1'b0, 1'b0);
        fill(32'h0500_0000, 32'h1500_0000, 2'd0, 3'b100, 1'b0, 1'b0);
        fill(32'h0600_0000, 32'h1600_0000, 2'd0, 3'b100, 1'b0, 1'b0);
        fill(32'h0700_0000, 32'h1700_0000, 2'd0, 3'b100, 1'b0, 1'b0);
        probe(32'h0200_0010, 1'b0, 1'b0, '0, "R5 R3 survivor oldest");
        for (int k = 4; k < 8; k++) begin
            probe(AW'(k) << 24, 1'b0, 1'b1, (AW'(k) << 24) + 32'h1000_0000, "R3 refill");
        end

        // R9: flush_local beats fill
        flush_local = 1'b1;
        fill(32'h0800_0000, 32'h1800_0000, 2'd0, 3'b100, 1'b0, 1'b1);
        flush_local = 1'b0;
        probe(32'h0800_0000, 1'b0, 1'b0, '0, "R9 fill dropped by flush_local");
        probe(32'h0400_0000, 1'b0, 1'b0, '0, "R5 nonglobal gone");

        // R5 R9: flush_all removes global slot and beats a fill
        fill(32'h0900_0000, 32'h1900_0000, 2'd0, 3'b100, 1'b0, 1'b1);
        flush_all = 1'b1;
        fill(32'h0A00_0000, 32'h1A00_0000, 2'd0, 3'b100, 1'b0, 1'b0);
        flush_all = 1'b0;
        probe(32'h0900_0000, 1'b0, 1'b0, '0, "R5 flush_all global gone");
        probe(32'h0A00_0000, 1'b0, 1'b0, '0, "R9 fill dropped by flush_all");

        // R9: fill beats touch. Order P,O,N,M; touch N with fill Q
        for (int k = 0; k < 4; k++) begin
            fill(32'h2000_0000 + (AW'(k) << 12), 32'h5000_0000 + (AW'(k) << 12),
                 2'd0, 3'b100, 1'b0, 1'b0);
        end
        lk_valid = 1'b1; lk_vaddr = 32'h2000_1000; lk_touch = 1'b1;
        fill(32'h2000_8000, 32'h5000_8000, 2'd0, 3'b100, 1'b0, 1'b0);
        lk_valid = 1'b0; lk_touch = 1'b0;
        // Q replaced M; order Q,P,O,N, so R replaces N
        fill(32'h2000_9000, 32'h5000_9000, 2'd0, 3'b100, 1'b0, 1'b0);
        probe(32'h2000_1000, 1'b0, 1'b0, '0, "R9 touch dropped");
        probe(32'h2000_2000, 1'b0, 1'b1, 32'h5000_2000, "R9 O kept");

        // R8: duplicate translations, lowest slot wins
        flush_all = 1'b1; step(); flush_all = 1'b0;
        fill(32'h3000_0000, 32'hAAAA_0000, 2'd0, 3'b100, 1'b0, 1'b0);
        fill(32'h3000_0000, 32'hBBBB_0000, 2'd0, 3'b100, 1'b0, 1'b0);
        probe(32'h3000_0123, 1'b0, 1'b1, 32'hAAAA_0123, "R8 lowest index");

        // R1: reserved size code acts as 4 KB
        fill(32'h3100_0000, 32'hCCCC_0000, 2'd3, 3'b100, 1'b0, 1'b0);
        probe(32'h3100_0FFF, 1'b0, 1'b1, 32'hCCCC_0FFF, "R1 code3 inside");
        probe(32'h3100_1000, 1'b0, 1'b0, '0, "R1 code3 outside");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule